// File: doc/BRIEF.md
# Tiled Bitmap Screen Address Generator

This block turns a tile coordinate into a byte address in a frame buffer that is built from 8x8 character tiles. Three configuration bytes set the geometry: a base byte that picks the start of the buffer in 1 KB steps, a mode byte that holds the colour depth and a two-bit height code, and a plot option byte whose object-mode bit forces the tallest layout. Given a tile column (0 to 31) and a tile row, the block gives the address where that column starts and the address of the addressed tile. Both addresses are registered, so they appear one clock after the inputs.

The block also reports the effective screen height in lines and the total screen size in bytes. When the buffer would run past the end of installed RAM, the base is pulled down so that the buffer ends exactly at the RAM limit. Installed RAM is a parameter counted in 64 KB banks, and all addresses are 18 bits wide and wrap modulo 2^18.

Top module: `scr_tile_addr`

## Requirements
- R1: The unclamped buffer base is the base byte multiplied by 1024.
- R2: The height code is mode bit 5 (high) and mode bit 2 (low). Codes 0, 1, 2 and 3 give 128, 160, 192 and 256 lines, reported on `eff_height`. All other mode bits above bit 1 are ignored.
- R3: When plot option bit 4 is 1, the effective height is 256 lines whatever the code. Screen size and base clamping still use the code's own height.
- R4: Colour mode is mode bits 1:0. Tile size is 16 bytes for mode 0, 32 bytes for mode 1 and 64 bytes for modes 2 and 3. Below 256 effective lines, column c starts at base + c × tile size.
- R5: At 256 effective lines, column c starts at base + c[4] × 512 × tile size + c[3:0] × 16 × tile size.
- R6: The tile address is the column start plus a row offset. Below 256 effective lines the offset is r × tile size × (lines/8). At 256 lines it is r[4] × 256 × tile size + r[3:0] × tile size.
- R7: For height codes 0 to 2, the screen size is (lines/8) × 32 × k, where k is 16, 32, 32 or 64 for colour modes 0 to 3. For code 3 it is 32768.
- R8: If base + screen size exceeds RAM_BANKS × 65536, the base used is RAM_BANKS × 65536 − screen size.
- R9: A row at or beyond (effective lines)/8 raises `row_oob`, and the tile address is then 0.
- R10: All outputs are registered. They show the result for the inputs present at the previous rising edge. While reset is high they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_reg | input | 8 | Buffer base in 1 KB units |
| mode_reg | input | 8 | Colour mode [1:0], height code bits [5] and [2] |
| plot_opt | input | 8 | Bit 4 selects object mode |
| tile_col | input | 5 | Tile column |
| tile_row | input | 5 | Tile row |
| col_addr | output | 18 | Registered column start address |
| tile_addr | output | 18 | Registered tile address, 0 when out of range |
| row_oob | output | 1 | Registered row out-of-range flag |
| eff_height | output | 9 | Registered effective height in lines |
| screen_size | output | 18 | Registered screen size in bytes |

## Verification
The bench sweeps every column against a set of rows placed at each height's row limit (15/16, 19/20, 23/24, 31) for all four colour modes, all four height codes and both object-mode settings. This separates the linear stride from the split 256-line stride, and shows that object mode changes the layout while leaving size and clamping alone. The base values run from zero to the top of the byte range, so both the unclamped base and the clamped base are exercised. Some of the mode bytes carry set bits outside the decoded fields, to show that those bits are ignored.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int ADDR_W = 18;
    localparam int COL_W  = 5;
    localparam int ROW_W  = 5;
    localparam int BASE_SHIFT = 10;

    typedef enum logic [1:0] {H128 = 2'd0, H160 = 2'd1, H192 = 2'd2, H256 = 2'd3} hcode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] size;
        logic [1:0]        cmode;
        hcode_e            eff_h;
    } geom_t;

    function automatic logic [8:0] lines_of(hcode_e h);
        case (h)
            H128:    return 9'd128;
            H160:    return 9'd160;
            H192:    return 9'd192;
            default: return 9'd256;
        endcase
    endfunction

    function automatic logic [5:0] rows_of(hcode_e h);
        return 6'(lines_of(h) >> 3);
    endfunction

    // log2 of bytes per tile for layout
    function automatic logic [2:0] tile_shift(logic [1:0] cm);
        case (cm)
            2'd0:    return 3'd4;
            2'd1:    return 3'd5;
            default: return 3'd6;
        endcase
    endfunction

    // log2 of size multiplier
    function automatic logic [2:0] size_shift(logic [1:0] cm);
        case (cm)
            2'd0:    return 3'd4;
            2'd3:    return 3'd6;
            default: return 3'd5;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] screen_bytes(hcode_e h, logic [1:0] cm);
        logic [ADDR_W-1:0] rows;
        rows = ADDR_W'(rows_of(h));
        if (h == H256) return ADDR_W'(32768);
        return rows << (5 + int'(size_shift(cm)));
    endfunction

endpackage

// File: rtl/scr_geom.sv
module scr_geom
    import scr_pkg::*;
#(
    parameter int RAM_BANKS = 2
) (
    input  logic [7:0] base_reg,
    input  logic [7:0] mode_reg,
    input  logic [7:0] plot_opt,
    output geom_t      geom
);
    localparam logic [ADDR_W:0] RAM_LIMIT = (ADDR_W+1)'(RAM_BANKS) << 16;

    hcode_e            raw_h;
    logic [ADDR_W-1:0] size;
    logic [ADDR_W-1:0] base_raw;
    logic [ADDR_W:0]   span_end;

    always_comb begin
        raw_h    = hcode_e'({mode_reg[5], mode_reg[2]});
        size     = screen_bytes(raw_h, mode_reg[1:0]);
        base_raw = ADDR_W'({base_reg, {BASE_SHIFT{1'b0}}});
        span_end = {1'b0, base_raw} + {1'b0, size};

        geom.cmode = mode_reg[1:0];
        geom.size  = size;
        geom.eff_h = plot_opt[4] ? H256 : raw_h;
        if (span_end > RAM_LIMIT)
            geom.base = ADDR_W'(RAM_LIMIT - {1'b0, size});
        else
            geom.base = base_raw;
    end
endmodule

// File: rtl/scr_addr.sv
module scr_addr
    import scr_pkg::*;
(
    input  geom_t              geom,
    input  logic [COL_W-1:0]   tile_col,
    input  logic [ROW_W-1:0]   tile_row,
    output logic [ADDR_W-1:0]  col_addr,
    output logic [ADDR_W-1:0]  tile_addr,
    output logic               row_oob
);
    logic [2:0]        ts;
    logic [5:0]        rows;
    logic [ADDR_W-1:0] col_off;
    logic [ADDR_W-1:0] row_off;
    logic [ADDR_W-1:0] col_w;
    logic [ADDR_W-1:0] row_w;

    always_comb begin
        ts    = tile_shift(geom.cmode);
        rows  = rows_of(geom.eff_h);
        col_w = ADDR_W'(tile_col);
        row_w = ADDR_W'(tile_row);
        if (geom.eff_h == H256) begin
            col_off = (ADDR_W'(tile_col[COL_W-1]) << (int'(ts) + 9))
                    + (ADDR_W'(tile_col[COL_W-2:0]) << (int'(ts) + 4));
            row_off = (ADDR_W'(tile_row[ROW_W-1]) << (int'(ts) + 8))
                    + (ADDR_W'(tile_row[ROW_W-2:0]) << int'(ts));
        end else begin
            col_off = col_w << int'(ts);
            row_off = ADDR_W'(row_w * ADDR_W'(rows)) << int'(ts);
        end
        row_oob   = {1'b0, tile_row} >= rows;
        col_addr  = geom.base + col_off;
        tile_addr = row_oob ? '0 : col_addr + row_off;
    end
endmodule

// File: rtl/scr_tile_addr.sv
module scr_tile_addr
    import scr_pkg::*;
#(
    parameter int RAM_BANKS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          base_reg,
    input  logic [7:0]          mode_reg,
    input  logic [7:0]          plot_opt,
    input  logic [COL_W-1:0]    tile_col,
    input  logic [ROW_W-1:0]    tile_row,
    output logic [ADDR_W-1:0]   col_addr,
    output logic [ADDR_W-1:0]   tile_addr,
    output logic                row_oob,
    output logic [8:0]          eff_height,
    output logic [ADDR_W-1:0]   screen_size
);
    localparam logic [ADDR_W:0] RAM_LIMIT = (ADDR_W+1)'(RAM_BANKS) << 16;

    geom_t             geom;
    logic [ADDR_W-1:0] col_c;
    logic [ADDR_W-1:0] tile_c;
    logic              oob_c;

    scr_geom #(.RAM_BANKS(RAM_BANKS)) u_geom (
        .base_reg (base_reg),
        .mode_reg (mode_reg),
        .plot_opt (plot_opt),
        .geom     (geom)
    );

    scr_addr u_addr (
        .geom      (geom),
        .tile_col  (tile_col),
        .tile_row  (tile_row),
        .col_addr  (col_c),
        .tile_addr (tile_c),
        .row_oob   (oob_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            col_addr    <= '0;
            tile_addr   <= '0;
            row_oob     <= 1'b0;
            eff_height  <= '0;
            screen_size <= '0;
        end else begin
            col_addr    <= col_c;
            tile_addr   <= tile_c;
            row_oob     <= oob_c;
            eff_height  <= lines_of(geom.eff_h);
            screen_size <= geom.size;
        end
    end

    p_height_legal_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (eff_height == 9'd128 || eff_height == 9'd160 ||
                  eff_height == 9'd192 || eff_height == 9'd256));

    p_obj_forces_r3: assert property (@(posedge clk) disable iff (rst)
        plot_opt[4] |=> eff_height == 9'd256);

    p_fits_ram_r8: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, geom.base} + {1'b0, geom.size}) <= RAM_LIMIT);

    p_oob_no_addr_r9: assert property (@(posedge clk) disable iff (rst)
        row_oob |-> tile_addr == '0);

    p_full_rows_r9: assert property (@(posedge clk) disable iff (rst)
        eff_height == 9'd256 |-> !row_oob);

endmodule

// File: tb/scr_tile_addr_test.sv
`timescale 1ns/1ps
module scr_tile_addr_test;
    localparam int BANKS = 2;
    localparam int LIM   = BANKS * 65536;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  base_reg = '0, mode_reg = '0, plot_opt = '0;
    logic [4:0]  tile_col = '0, tile_row = '0;
    logic [17:0] col_addr, tile_addr, screen_size;
    logic        row_oob;
    logic [8:0]  eff_height;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    scr_tile_addr #(.RAM_BANKS(BANKS)) uut (
        .clk(clk), .rst(rst), .base_reg(base_reg), .mode_reg(mode_reg),
        .plot_opt(plot_opt), .tile_col(tile_col), .tile_row(tile_row),
        .col_addr(col_addr), .tile_addr(tile_addr), .row_oob(row_oob),
        .eff_height(eff_height), .screen_size(screen_size)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input int b, input int m, input int p, input int c, input int r);
        int hc, hl, eh, cm, tsz, mult, size, base, rows, cs, ro, ta;
        bit oob;
        base_reg = 8'(b); mode_reg = 8'(m); plot_opt = 8'(p);
        tile_col = 5'(c); tile_row = 5'(r);
        @(posedge clk); #1;
        hc   = ((m >> 5) & 1) * 2 + ((m >> 2) & 1);
        hl   = (hc == 3) ? 256 : 128 + 32 * hc;
        eh   = ((p >> 4) & 1) ? 256 : hl;
        cm   = m & 3;
        tsz  = (cm == 0) ? 16 : (cm == 1) ? 32 : 64;
        mult = (cm == 0) ? 16 : (cm == 3) ? 64 : 32;
        size = (hc == 3) ? 32768 : (hl / 8) * 32 * mult;
        base = b * 1024;
        if (base + size > LIM) base = LIM - size;
        rows = eh / 8;
        if (eh == 256) begin
            cs = base + (c / 16) * 512 * tsz + (c % 16) * 16 * tsz;
            ro = (r / 16) * 256 * tsz + (r % 16) * tsz;
        end else begin
            cs = base + c * tsz;
            ro = r * tsz * rows;
        end
        oob = r >= rows;
        ta  = oob ? 0 : (cs + ro) % 262144;
        cs  = cs % 262144;
        check(eff_height == 9'(eh), "R2/R3 eff_height", int'(eff_height), eh);
        check(screen_size == 18'(size), "R7 screen_size", int'(screen_size), size);
        check(col_addr == 18'(cs), "R1/R4/R5/R8 col_addr", int'(col_addr), cs);
        check(tile_addr == 18'(ta), "R6/R9 tile_addr", int'(tile_addr), ta);
        check(row_oob == oob, "R9 row_oob", int'(row_oob), int'(oob));
    endtask

    initial begin
        int rowset [10] = '{0, 1, 7, 15, 16, 19, 20, 23, 24, 31};
        int bases  [4]  = '{0, 8'h40, 8'h7F, 8'hFF};
        base_reg = 8'hFF; mode_reg = 8'hFF; plot_opt = 8'hFF;
        tile_col = 5'd31; tile_row = 5'd31;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check(col_addr == 0 && tile_addr == 0 && !row_oob && eff_height == 0 && screen_size == 0,
              "R10 reset outputs", int'(col_addr) + int'(tile_addr) + int'(eff_height), 0);
        @(negedge clk); rst = 1'b0;
        // R1: plain base, no clamp
        apply(8'h10, 0, 0, 0, 0);
        check(col_addr == 18'h4000, "R1 base*1024", int'(col_addr), 'h4000);
        // R8: clamp at top of RAM: 192 lines, mode 3 -> 49152 bytes
        apply(8'hFF, 8'h20 | 3, 0, 0, 0);
        check(col_addr == 18'(LIM - 49152), "R8 clamp", int'(col_addr), LIM - 49152);
        // R10: result follows inputs with one-cycle latency
        apply(8'h00, 1, 0, 3, 0);
        check(col_addr == 18'd96, "R10 latency", int'(col_addr), 96);
        // R2 ignored bits: bits 3,4,6,7 set
        apply(8'h00, 8'hD8 | 1, 0, 2, 0);
        check(eff_height == 9'd128 && col_addr == 18'd64, "R2 ignored bits",
              int'(eff_height), 128);
        foreach (bases[bi])
            for (int hc = 0; hc < 4; hc++)
                for (int cm = 0; cm < 4; cm++)
                    for (int p = 0; p < 2; p++)
                        for (int c = 0; c < 32; c++)
                            foreach (rowset[ri]) begin
                                int m;
                                m = ((hc >> 1) << 5) | ((hc & 1) << 2) | cm;
                                if (c[0]) m = m | 8'h48;
                                apply(bases[bi], m, p ? 8'h10 : (c[1] ? 8'hEF : 0), c, rowset[ri]);
                            end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule